// File: doc/BRIEF.md
# Region-based secure access checker

This block sits in front of a memory and gives a verdict on every access presented to it. It holds up to nine address regions. Each region has a 64-bit base and a 64-bit top, both on 4 KB boundaries, with the top treated as inclusive. Each region also has a bitmap that enables it on individual filters, a 2-bit permission that applies to secure accesses, and a 32-bit mask of the non-secure device IDs that may read or write it. Region 0 is a background region. It always covers the whole address space on every filter, so only its permission and its ID mask can be programmed.

Software sets up the regions through a small register port. The word address is formed as `{region, field}`. A write lands on the clock edge, and reads are combinational.

An access carries an address, a direction, a secure flag, a device ID and a filter index. Among the regions that contain the address and are enabled for that filter, the one with the highest number decides. One clock after the request the block returns a permit or deny verdict together with the index of the deciding region.

Top module: `region_access_checker`

## Requirements
- R1: After reset every region has permission 0, filter enables 0, an ID mask of 0 and zero bounds, so every access is denied by region 0. Region 0 attribute reads 0x0000000F and region 1 attribute reads 0.
- R2: A request sampled with `acc_valid_i` high produces `resp_valid_o` high on the next clock, with exactly one of `permit_o` and `deny_o` set. When no response is pending, `resp_valid_o`, `permit_o` and `deny_o` are all low.
- R3: For region 0, base words read 0, top words read 0xFFFFFFFF and the attribute filter bits read all ones. Writes to its bounds or filter bits are ignored. Its permission and ID mask fields are writable.
- R4: The register word address is `reg_addr_i = {region[3:0], field[2:0]}`. The field codes are 0 for base low, 1 for base high, 2 for top low, 3 for top high, 4 for attributes and 5 for the ID mask. Bits 11:0 of base low always read 0 and bits 11:0 of top low always read 0xFFF.
- R5: An address falls in region r (r ≥ 1) when base ≤ addr ≤ {top[63:12], 12'hFFF}. Both ends are inclusive.
- R6: Region r (r ≥ 1) is considered only if bit `acc_filter_i` of its attribute filter field (bits 3:0) is set.
- R7: The highest-numbered qualifying region decides, and region 0 is used when no other region qualifies. Its index appears on `region_o`.
- R8: A secure access uses attribute bits 31:30 of the deciding region: 0 gives no access, 1 read only, 2 write only and 3 read and write.
- R9: A non-secure read is permitted only if ID-mask bit `acc_id_i` is set. A non-secure write is permitted only if ID-mask bit `16 + acc_id_i` is set.
- R10: Writes to a region index of 9 or above, or to field codes 6 and 7, are ignored and have no effect on decisions. Such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register word address {region, field} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| acc_valid_i | input | 1 | Access request valid |
| acc_addr_i | input | 64 | Access address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_secure_i | input | 1 | 1 = secure access |
| acc_id_i | input | 4 | Non-secure device ID |
| acc_filter_i | input | 2 | Filter index of the access |
| resp_valid_o | output | 1 | Verdict valid, one clock after the request |
| permit_o | output | 1 | Access permitted |
| deny_o | output | 1 | Access denied |
| region_o | output | 4 | Index of the deciding region |

## Verification
Addresses are placed on the last and first 4 KB page of a region and one byte outside it on each side, which distinguishes inclusive from exclusive bound compares. The same address is presented on a filter that is enabled for the region and on one that is not, which shows whether the bitmap gates the match. An overlap of two regions with opposite permissions shows whether the priority order is correct. Each secure permission code and each direction of the ID mask are tried against both directions, and a randomised phase then mixes reprogramming with accesses while a behavioural model follows every clock.

// File: rtl/region_chk_pkg.sv
package region_chk_pkg;
  localparam int PAGE_BITS = 12;
  localparam int FLD_W     = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_BASE_LO = 3'd0,
    FLD_BASE_HI = 3'd1,
    FLD_TOP_LO  = 3'd2,
    FLD_TOP_HI  = 3'd3,
    FLD_ATTR    = 3'd4,
    FLD_IDMASK  = 3'd5
  } fld_e;
endpackage

// File: rtl/region_regfile.sv
module region_regfile
  import region_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 64,
  localparam int RIDX_W     = $clog2(NUM_REGIONS),
  localparam int RA_W       = RIDX_W + FLD_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [RA_W-1:0]        addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [ADDR_W-1:0]      base_o [NUM_REGIONS],
  output logic [ADDR_W-1:0]      top_o  [NUM_REGIONS],
  output logic [1:0]             perm_o [NUM_REGIONS],
  output logic [NUM_FILTERS-1:0] fen_o  [NUM_REGIONS],
  output logic [31:0]            idm_o  [NUM_REGIONS]
);
  localparam int PG_W  = ADDR_W - PAGE_BITS;
  localparam int LO_PG = 32 - PAGE_BITS;
  localparam int HI_W  = ADDR_W - 32;

  logic [RIDX_W-1:0] rsel;
  fld_e              fsel;
  assign rsel = addr_i[RA_W-1:FLD_W];
  assign fsel = fld_e'(addr_i[FLD_W-1:0]);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
    logic hit;
    logic [1:0]  perm_q;
    logic [31:0] idm_q;
    assign hit = we_i && (rsel == RIDX_W'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        perm_q <= '0;
        idm_q  <= '0;
      end else if (hit) begin
        if (fsel == FLD_ATTR)   perm_q <= wdata_i[31:30];
        if (fsel == FLD_IDMASK) idm_q  <= wdata_i;
      end
    end
    assign perm_o[r] = perm_q;
    assign idm_o[r]  = idm_q;

    if (r == 0) begin : g_bg
      // background region: fixed span, enabled on every filter
      assign base_o[r] = '0;
      assign top_o[r]  = '1;
      assign fen_o[r]  = '1;
    end else begin : g_prog
      logic [PG_W-1:0]        base_q, top_q;
      logic [NUM_FILTERS-1:0] fen_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q <= '0;
          top_q  <= '0;
          fen_q  <= '0;
        end else if (hit) begin
          case (fsel)
            FLD_BASE_LO: base_q[LO_PG-1:0]    <= wdata_i[31:PAGE_BITS];
            FLD_BASE_HI: base_q[PG_W-1:LO_PG] <= wdata_i[HI_W-1:0];
            FLD_TOP_LO:  top_q[LO_PG-1:0]     <= wdata_i[31:PAGE_BITS];
            FLD_TOP_HI:  top_q[PG_W-1:LO_PG]  <= wdata_i[HI_W-1:0];
            FLD_ATTR:    fen_q                <= wdata_i[NUM_FILTERS-1:0];
            default: ;
          endcase
        end
      end
      assign base_o[r] = {base_q, {PAGE_BITS{1'b0}}};
      assign top_o[r]  = {top_q, {PAGE_BITS{1'b1}}};
      assign fen_o[r]  = fen_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(rsel) < NUM_REGIONS) begin
      case (fsel)
        FLD_BASE_LO: rdata_o = base_o[rsel][31:0];
        FLD_BASE_HI: rdata_o = 32'(base_o[rsel][ADDR_W-1:32]);
        FLD_TOP_LO:  rdata_o = top_o[rsel][31:0];
        FLD_TOP_HI:  rdata_o = 32'(top_o[rsel][ADDR_W-1:32]);
        FLD_ATTR:    rdata_o = {perm_o[rsel], {(30-NUM_FILTERS){1'b0}}, fen_o[rsel]};
        FLD_IDMASK:  rdata_o = idm_o[rsel];
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/region_match.sv
module region_match #(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int ADDR_W      = 64,
  localparam int FSEL_W     = $clog2(NUM_FILTERS)
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [FSEL_W-1:0]      filter_i,
  input  logic [ADDR_W-1:0]      base_i [NUM_REGIONS],
  input  logic [ADDR_W-1:0]      top_i  [NUM_REGIONS],
  input  logic [NUM_FILTERS-1:0] fen_i  [NUM_REGIONS],
  output logic [NUM_REGIONS-1:0] hit_o
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign hit_o[r] = fen_i[r][filter_i] && (addr_i >= base_i[r]) && (addr_i <= top_i[r]);
  end
endmodule

// File: rtl/region_select.sv
module region_select #(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_IDS     = 16,
  localparam int RIDX_W     = $clog2(NUM_REGIONS),
  localparam int ID_W       = $clog2(NUM_IDS)
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  input  logic [1:0]             perm_i [NUM_REGIONS],
  input  logic [31:0]            idm_i  [NUM_REGIONS],
  input  logic                   write_i,
  input  logic                   secure_i,
  input  logic [ID_W-1:0]        id_i,
  output logic [RIDX_W-1:0]      win_o,
  output logic                   permit_o
);
  logic [1:0]  perm;
  logic [31:0] idm;
  logic [4:0]  id_bit;

  // later (higher) hits overwrite earlier ones
  always_comb begin
    win_o = '0;
    for (int r = 1; r < NUM_REGIONS; r++) begin
      if (hit_i[r]) win_o = RIDX_W'(r);
    end
  end

  assign perm   = perm_i[win_o];
  assign idm    = idm_i[win_o];
  assign id_bit = write_i ? 5'(NUM_IDS + int'(id_i)) : 5'(id_i);

  always_comb begin
    if (secure_i) permit_o = write_i ? perm[1] : perm[0];
    else          permit_o = idm[id_bit];
  end
endmodule

// File: rtl/region_access_checker.sv
module region_access_checker
  import region_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 9,
  parameter int NUM_FILTERS = 4,
  parameter int NUM_IDS     = 16,
  parameter int ADDR_W      = 64,
  localparam int RIDX_W     = $clog2(NUM_REGIONS),
  localparam int RA_W       = RIDX_W + FLD_W,
  localparam int FSEL_W     = $clog2(NUM_FILTERS),
  localparam int ID_W       = $clog2(NUM_IDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_secure_i,
  input  logic [ID_W-1:0]   acc_id_i,
  input  logic [FSEL_W-1:0] acc_filter_i,
  output logic              resp_valid_o,
  output logic              permit_o,
  output logic              deny_o,
  output logic [RIDX_W-1:0] region_o
);
  logic [ADDR_W-1:0]      base [NUM_REGIONS];
  logic [ADDR_W-1:0]      top  [NUM_REGIONS];
  logic [1:0]             perm [NUM_REGIONS];
  logic [NUM_FILTERS-1:0] fen  [NUM_REGIONS];
  logic [31:0]            idm  [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] hit;
  logic [RIDX_W-1:0]      win;
  logic                   ok;

  region_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .base_o(base), .top_o(top), .perm_o(perm), .fen_o(fen), .idm_o(idm)
  );

  region_match #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_FILTERS(NUM_FILTERS), .ADDR_W(ADDR_W)
  ) u_match (
    .addr_i(acc_addr_i), .filter_i(acc_filter_i),
    .base_i(base), .top_i(top), .fen_i(fen), .hit_o(hit)
  );

  region_select #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_IDS(NUM_IDS)
  ) u_sel (
    .hit_i(hit), .perm_i(perm), .idm_i(idm), .write_i(acc_write_i),
    .secure_i(acc_secure_i), .id_i(acc_id_i), .win_o(win), .permit_o(ok)
  );

  logic              vld_q, ok_q;
  logic [RIDX_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
      win_q <= '0;
    end else begin
      vld_q <= acc_valid_i;
      ok_q  <= acc_valid_i && ok;
      if (acc_valid_i) win_q <= win;
    end
  end

  assign resp_valid_o = vld_q;
  assign permit_o     = ok_q;
  assign deny_o       = vld_q && !ok_q;
  assign region_o     = win_q;
endmodule

// File: rtl/region_access_checker_chk.sv
module region_access_checker_chk #(
  parameter int NUM_REGIONS = 9,
  parameter int RIDX_W      = 4,
  parameter int RA_W        = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              acc_valid_i,
  input logic              resp_valid_o,
  input logic              permit_o,
  input logic              deny_o,
  input logic [RIDX_W-1:0] region_o
);
  // R2
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o == $past(acc_valid_i));
  // R2
  verdict_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $countones({permit_o, deny_o}) == 1);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !permit_o && !deny_o);
  // R3
  bg_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_W'(0) || reg_addr_i == RA_W'(1)) |-> reg_rdata_o == 32'h0);
  // R3
  bg_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == RA_W'(2) || reg_addr_i == RA_W'(3)) |-> reg_rdata_o == 32'hFFFF_FFFF);
  // R7
  region_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> int'(region_o) < NUM_REGIONS);
  // R10
  oob_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_addr_i[RA_W-1:3]) >= NUM_REGIONS || reg_addr_i[2:1] == 2'b11) |-> reg_rdata_o == 32'h0);
endmodule

bind region_access_checker region_access_checker_chk #(
  .NUM_REGIONS(NUM_REGIONS), .RIDX_W(RIDX_W), .RA_W(RA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .acc_valid_i(acc_valid_i), .resp_valid_o(resp_valid_o), .permit_o(permit_o),
  .deny_o(deny_o), .region_o(region_o)
);

// File: tb/region_access_checker_test.sv
`timescale 1ns/1ps
module region_access_checker_test;
  localparam int NR = 9;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [6:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        acc_valid = 0, acc_write = 0, acc_secure = 0;
  logic [63:0] acc_addr = 0;
  logic [3:0]  acc_id = 0;
  logic [1:0]  acc_filter = 0;
  logic        resp_valid, permit, deny;
  logic [3:0]  region;

  always #2 clk = ~clk;

  region_access_checker uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .acc_valid_i(acc_valid),
    .acc_addr_i(acc_addr), .acc_write_i(acc_write), .acc_secure_i(acc_secure),
    .acc_id_i(acc_id), .acc_filter_i(acc_filter), .resp_valid_o(resp_valid),
    .permit_o(permit), .deny_o(deny), .region_o(region)
  );

  int n_checks = 0, n_errors = 0;
  string cur_tag = "R1", exp_tag = "R1";
  bit done = 0;

  // behavioural model
  logic [63:0] m_base [NR];
  logic [63:0] m_top  [NR];
  logic [1:0]  m_perm [NR];
  logic [3:0]  m_fen  [NR];
  logic [31:0] m_idm  [NR];
  logic        exp_v = 0, exp_p = 0;
  logic [3:0]  exp_r = 0;

  task automatic m_reset();
    for (int r = 0; r < NR; r++) begin
      m_base[r] = 0; m_top[r] = 64'hFFF; m_perm[r] = 0; m_fen[r] = 0; m_idm[r] = 0;
    end
    m_top[0] = '1; m_fen[0] = 4'hF;
  endtask

  function automatic logic [31:0] m_read(logic [6:0] a);
    int r = int'(a[6:3]);
    if (r >= NR) return 0;
    case (a[2:0])
      3'd0: return m_base[r][31:0];
      3'd1: return m_base[r][63:32];
      3'd2: return m_top[r][31:0];
      3'd3: return m_top[r][63:32];
      3'd4: return {m_perm[r], 26'b0, m_fen[r]};
      3'd5: return m_idm[r];
      default: return 0;
    endcase
  endfunction

  task automatic m_write(logic [6:0] a, logic [31:0] d);
    int r = int'(a[6:3]);
    if (r >= NR) return;
    case (a[2:0])
      3'd4: begin m_perm[r] = d[31:30]; if (r != 0) m_fen[r] = d[3:0]; end
      3'd5: m_idm[r] = d;
      default: if (r != 0) case (a[2:0])
        3'd0: m_base[r][31:12] = d[31:12];
        3'd1: m_base[r][63:32] = d;
        3'd2: m_top[r][31:12]  = d[31:12];
        3'd3: m_top[r][63:32]  = d;
        default: ;
      endcase
    endcase
  endtask

  function automatic logic [4:0] m_decide(logic [63:0] a, logic wr, logic sec,
                                          logic [3:0] id, logic [1:0] f);
    int w = 0;
    logic p;
    for (int r = 1; r < NR; r++)
      if (m_fen[r][f] && a >= m_base[r] && a <= m_top[r]) w = r;
    if (sec) p = wr ? m_perm[w][1] : m_perm[w][0];
    else     p = m_idm[w][wr ? 16 + int'(id) : int'(id)];
    return {p, 4'(w)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reset();
      exp_v <= 0; exp_p <= 0; exp_r <= 0; exp_tag <= "R1";
    end else begin
      logic [4:0] d;
      d = m_decide(acc_addr, acc_write, acc_secure, acc_id, acc_filter);
      exp_v <= acc_valid;
      exp_p <= acc_valid && d[4];
      if (acc_valid) exp_r <= d[3:0];
      exp_tag <= cur_tag;
      if (reg_we) m_write(reg_addr, reg_wdata);
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the model (R2 timing, verdict, region)
  always @(negedge clk) begin
    if (!done) begin
      check(exp_tag, {resp_valid, permit, deny}, {exp_v, exp_p, exp_v & ~exp_p}, "model verdict");
      if (exp_v) check(exp_tag, region, exp_r, "model region");
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    acc_valid = 0; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(string tag, logic [6:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_we = 0; acc_valid = 0; reg_addr = a;
    #1;
    check(tag, reg_rdata, exp, "readback");
    check(tag, reg_rdata, m_read(a), "readback model");
  endtask

  task automatic acc(string tag, logic [63:0] a, logic w, logic s, logic [3:0] id,
                     logic [1:0] f, logic exp_permit, logic [3:0] exp_region);
    @(negedge clk);
    cur_tag = tag; reg_we = 0;
    acc_valid = 1; acc_addr = a; acc_write = w; acc_secure = s; acc_id = id; acc_filter = f;
    @(negedge clk);
    acc_valid = 0;
    #1;
    check(tag, {resp_valid, permit, deny}, {1'b1, exp_permit, ~exp_permit}, "verdict");
    check(tag, region, exp_region, "region");
  endtask

  initial begin
    #200000;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {resp_valid, permit, deny}, 3'b000, "reset outputs");
    rst_n = 1;
    // R1 reset state
    rd("R1", 7'h04, 32'h0000_000F);
    rd("R1", 7'h0C, 32'h0);
    rd("R1", 7'h05, 32'h0);
    acc("R1", 64'h0, 0, 1, 0, 0, 0, 0);
    // R8 secure permission codes on region 0
    wr(7'h04, 32'h4000_0000);
    acc("R8", 64'h100, 0, 1, 0, 0, 1, 0);
    acc("R8", 64'h100, 1, 1, 0, 0, 0, 0);
    wr(7'h04, 32'h8000_0000);
    acc("R8", 64'h100, 0, 1, 0, 0, 0, 0);
    acc("R8", 64'h100, 1, 1, 0, 0, 1, 0);
    wr(7'h04, 32'hC000_0000);
    acc("R8", 64'h100, 1, 1, 0, 3, 1, 0);
    // R3 background region is fixed
    wr(7'h00, 32'hFFFF_F000);
    wr(7'h02, 32'h0000_1000);
    wr(7'h04, 32'hC000_0000);
    rd("R3", 7'h00, 32'h0);
    rd("R3", 7'h02, 32'hFFFF_FFFF);
    rd("R3", 7'h03, 32'hFFFF_FFFF);
    rd("R3", 7'h04, 32'hC000_000F);
    acc("R3", 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 2, 1, 0);
    // region 2: [0x1_0000_2000, 0x1_0000_4FFF], filter 1, no secure access
    wr(7'h10, 32'h0000_2ABC);
    wr(7'h11, 32'h0000_0001);
    wr(7'h12, 32'h0000_4000);
    wr(7'h13, 32'h0000_0001);
    wr(7'h14, 32'h0000_0002);
    // R4 field map and page granularity
    rd("R4", 7'h10, 32'h0000_2000);
    rd("R4", 7'h11, 32'h0000_0001);
    rd("R4", 7'h12, 32'h0000_4FFF);
    rd("R4", 7'h14, 32'h0000_0002);
    // R5 inclusive bounds
    acc("R5", 64'h1_0000_2000, 0, 1, 0, 1, 0, 2);
    acc("R5", 64'h1_0000_1FFF, 0, 1, 0, 1, 1, 0);
    acc("R5", 64'h1_0000_4FFF, 0, 1, 0, 1, 0, 2);
    acc("R5", 64'h1_0000_5000, 0, 1, 0, 1, 1, 0);
    // R6 filter enable gating
    acc("R6", 64'h1_0000_3000, 0, 1, 0, 0, 1, 0);
    acc("R6", 64'h1_0000_3000, 0, 1, 0, 1, 0, 2);
    // R7 region 5 overlaps region 2, all filters, read/write
    wr(7'h28, 32'h0000_3000);
    wr(7'h29, 32'h0000_0001);
    wr(7'h2A, 32'h0000_3000);
    wr(7'h2B, 32'h0000_0001);
    wr(7'h2C, 32'hC000_000F);
    acc("R7", 64'h1_0000_3800, 1, 1, 0, 1, 1, 5);
    acc("R7", 64'h1_0000_2800, 1, 1, 0, 1, 0, 2);
    acc("R7", 64'h1_0000_3FFF, 0, 1, 0, 3, 1, 5);
    // R9 non-secure device masks on region 5
    wr(7'h2D, 32'h0080_0008);
    acc("R9", 64'h1_0000_3800, 0, 0, 3, 2, 1, 5);
    acc("R9", 64'h1_0000_3800, 1, 0, 3, 2, 0, 5);
    acc("R9", 64'h1_0000_3800, 1, 0, 7, 2, 1, 5);
    acc("R9", 64'h1_0000_3800, 0, 0, 7, 2, 0, 5);
    // R10 out-of-range writes ignored
    wr(7'h4C, 32'hC000_000F);
    wr(7'h78, 32'h0000_0000);
    wr(7'h2E, 32'hFFFF_FFFF);
    rd("R10", 7'h4C, 32'h0);
    rd("R10", 7'h2E, 32'h0);
    rd("R10", 7'h2C, 32'hC000_000F);
    acc("R10", 64'h1_0000_3800, 1, 1, 0, 1, 1, 5);
    // randomised mix, followed by the model every clock
    cur_tag = "R7";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      reg_we = 0; acc_valid = 0;
      if ($urandom_range(0, 3) == 0) begin
        reg_we = 1;
        reg_addr = {4'($urandom_range(0, 10)), 3'($urandom_range(0, 7))};
        reg_wdata = (reg_addr[2:0] == 3'd1 || reg_addr[2:0] == 3'd3) ?
                    32'($urandom_range(0, 1)) : $urandom;
      end else begin
        acc_valid = 1;
        acc_addr = ($urandom_range(0, 7) == 0) ? {$urandom, $urandom} :
                   64'h1_0000_0000 + 64'($urandom_range(0, 32'h8000));
        acc_write = 1'($urandom); acc_secure = 1'($urandom);
        acc_id = 4'($urandom); acc_filter = 2'($urandom);
      end
    end
    @(negedge clk);
    reg_we = 0; acc_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule